// File: doc/BRIEF.md
# Triple Converter Serial Control Interface

This block is the digital front end of a three-channel 8-bit converter. A host writes it through a three-wire serial port made of an active-low select, a serial clock and a data line. Each write carries a 16-bit word, most significant bit first: a control byte, then a data byte. The three port lines are brought into the system clock domain through two-flop synchronisers. Serial clock and select edges are found there. The system clock must run at least four times faster than the serial clock.

When the select line is released after exactly sixteen serial clock rising edges, the word is decoded. The data byte goes into every channel whose load flag is set, all in the same cycle. Each channel's shutdown flag takes its new value, and the general-purpose logic output follows its control bit. A word of any other length is dropped. In shutdown, channels A and B report a floating output but keep showing their stored code. Channel C reports an output forced to zero, and its code port reads 0x00. Every channel's stored code survives shutdown.

Control word layout, bit 15 first on the wire: bit 15 unused, bit 14 logic output, bits 13/12/11 shutdown for C/B/A, bits 10/9/8 load for C/B/A, bits 7..0 data. Output state encoding: 0 = driving, 1 = high impedance, 2 = forced to zero.

Top module: `triple_dac_if`

## Requirements
- R1: While `rst` is high and right after it falls, code_a = code_b = 0xFF, code_c = 0x00, all three states read 0 (driving) and `lout` is 0.
- R2: A 16-bit word (bit 15 first) with load bits 8/9/10 writes the data byte (bits 7..0) into channels A/B/C respectively, for any subset of the three. Channels whose load bit is clear keep their code.
- R3: A word sent as two 8-bit bursts, with the select held low across the pause, has the same effect as a continuous word.
- R4: If the select rises after any bit count other than 16 (for example 8, 15 or 17), no output changes.
- R5: After a word with shutdown bit 11/12 set, channel A/B state reads 1 (high impedance) and its code port still shows its stored code. After a word with bit 13 set, channel C state reads 2 (forced zero) and code_c reads 0x00.
- R6: A later word with a shutdown bit clear returns that channel to state 0, and its code port shows the code stored before the shutdown.
- R7: `lout` takes the value of bit 14 from each accepted word, including words that shut channels down.
- R8: Serial clock edges while the select is high shift nothing. The next full word is decoded correctly.
- R9: Bit 15 has no effect on any output.
- R10: Outputs do not change until the select rises, even after all 16 bits have been clocked in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, data sampled on rising edges |
| sdin | input | 1 | Serial data, most significant bit first |
| code_a | output | 8 | Channel A code |
| code_b | output | 8 | Channel B code |
| code_c | output | 8 | Channel C code (0x00 while shut down) |
| state_a | output | 2 | Channel A output state |
| state_b | output | 2 | Channel B output state |
| state_c | output | 2 | Channel C output state |
| lout | output | 1 | General-purpose logic output |

## Verification
All eight load masks are swept, each with a different data byte. This shows whether every subset of channels receives the byte while the others hold. All eight shutdown masks are then swept with `lout` toggling, which separates the floating behaviour of A/B from the forced zero of C. A final word clears the shutdowns and checks that the stored codes come back. Further patterns cover truncated and overlong words, a split transfer with a pause, stray serial clocks while deselected, the unused top bit, and a full word still held open by the select. Each of these is told apart from a correct write by comparing against a bench-side model.

// File: rtl/triple_dac_pkg.sv
package triple_dac_pkg;
  localparam int NUM_CH = 3;
  localparam logic [1:0] ST_DRIVE = 2'd0;
  localparam logic [1:0] ST_HIZ   = 2'd1;
  localparam logic [1:0] ST_ZERO  = 2'd2;
endpackage

// File: rtl/tdac_sync.sv
module tdac_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/tdac_shifter.sv
module tdac_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              sdin_s,
  output logic              word_stb,
  output logic [WORD_W-2:0] word_q
);
  localparam int KEEP_W  = WORD_W - 1;
  localparam int CNT_W   = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(WORD_W + 1);

  logic [KEEP_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;
  logic              sclk_d, cs_d;
  logic              sclk_rise, cs_rise;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign cs_rise   = cs_n_s & ~cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr       <= '0;
      cnt      <= '0;
      sclk_d   <= 1'b0;
      cs_d     <= 1'b1;
      word_stb <= 1'b0;
    end else begin
      sclk_d   <= sclk_s;
      cs_d     <= cs_n_s;
      word_stb <= cs_rise && (cnt == CNT_FULL);
      if (cs_n_s) begin
        cnt <= '0;
      end else if (sclk_rise) begin
        sr <= {sr[KEEP_W-2:0], sdin_s};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
    end
  end

  assign word_q = sr;

  // R8: a released select holds the bit counter at zero
  a_r8_count_idle: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> (cnt == '0));

  // R10: a decode strobe is only seen with the select released
  a_r10_strobe_released: assert property (@(posedge clk) disable iff (rst)
    word_stb |-> cs_n_s);

  // R8: while deselected the shift register does not move
  a_r8_sr_frozen: assert property (@(posedge clk) disable iff (rst)
    (cs_n_s && cs_d) |=> $stable(sr));
endmodule

// File: rtl/tdac_channel.sv
module tdac_channel
  import triple_dac_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] RESET_CODE = '1,
  parameter bit OFF_ZERO = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic              load,
  input  logic              shdn,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] code_o,
  output logic [1:0]        state_o
);
  logic [DATA_W-1:0] code_q;
  logic              shdn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= RESET_CODE;
      shdn_q <= 1'b0;
    end else if (upd) begin
      if (load) code_q <= data;
      shdn_q <= shdn;
    end
  end

  generate
    if (OFF_ZERO) begin : g_zero
      always_ff @(posedge clk) begin
        if (rst) begin
          code_o  <= RESET_CODE;
          state_o <= ST_DRIVE;
        end else begin
          code_o  <= shdn_q ? '0 : code_q;
          state_o <= shdn_q ? ST_ZERO : ST_DRIVE;
        end
      end
    end else begin : g_float
      always_ff @(posedge clk) begin
        if (rst) begin
          code_o  <= RESET_CODE;
          state_o <= ST_DRIVE;
        end else begin
          code_o  <= code_q;
          state_o <= shdn_q ? ST_HIZ : ST_DRIVE;
        end
      end
    end
  endgenerate

  // R2/R6: stored code only moves on a load
  a_r2_code_hold: assert property (@(posedge clk) disable iff (rst)
    !(upd && load) |=> $stable(code_q));

  // R5: a shut-down channel never reports driving
  a_r5_off_state: assert property (@(posedge clk) disable iff (rst)
    shdn_q |=> (state_o != ST_DRIVE));
endmodule

// File: rtl/triple_dac_if.sv
module triple_dac_if
  import triple_dac_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdin,
  output logic [DATA_W-1:0] code_a,
  output logic [DATA_W-1:0] code_b,
  output logic [DATA_W-1:0] code_c,
  output logic [1:0]        state_a,
  output logic [1:0]        state_b,
  output logic [1:0]        state_c,
  output logic              lout
);
  localparam int WORD_W = DATA_W + 8;
  localparam int LD_LSB = DATA_W;
  localparam int SD_LSB = DATA_W + NUM_CH;
  localparam int LO_BIT = DATA_W + 2 * NUM_CH;

  logic [2:0]        pins_s;
  logic              word_stb;
  logic [WORD_W-2:0] word_q;
  logic [DATA_W-1:0] ch_code  [NUM_CH];
  logic [1:0]        ch_state [NUM_CH];
  logic              lout_q;

  tdac_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, sclk, sdin}), .q(pins_s)
  );

  tdac_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .cs_n_s(pins_s[2]), .sclk_s(pins_s[1]),
    .sdin_s(pins_s[0]), .word_stb(word_stb), .word_q(word_q)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam bit IS_C = (i == NUM_CH - 1);
      tdac_channel #(
        .DATA_W(DATA_W),
        .RESET_CODE(IS_C ? {DATA_W{1'b0}} : {DATA_W{1'b1}}),
        .OFF_ZERO(IS_C)
      ) u_ch (
        .clk(clk), .rst(rst), .upd(word_stb),
        .load(word_q[LD_LSB + i]), .shdn(word_q[SD_LSB + i]),
        .data(word_q[DATA_W-1:0]),
        .code_o(ch_code[i]), .state_o(ch_state[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) lout_q <= 1'b0;
    else if (word_stb) lout_q <= word_q[LO_BIT];
  end

  assign code_a  = ch_code[0];
  assign code_b  = ch_code[1];
  assign code_c  = ch_code[2];
  assign state_a = ch_state[0];
  assign state_b = ch_state[1];
  assign state_c = ch_state[2];
  assign lout    = lout_q;

  // R7: logic output only moves after an accepted word
  a_r7_lout_hold: assert property (@(posedge clk) disable iff (rst)
    !word_stb |=> $stable(lout));

  // R1: defaults visible right after reset
  a_r1_defaults: assert property (@(posedge clk)
    $past(rst) |-> (code_a == '1 && code_b == '1 && code_c == '0 &&
                    state_a == ST_DRIVE && state_b == ST_DRIVE &&
                    state_c == ST_DRIVE && !lout));

  // R5: channel C reads zero whenever it reports forced-zero
  a_r5_c_zero: assert property (@(posedge clk) disable iff (rst)
    (state_c == ST_ZERO) |-> (code_c == '0));
endmodule

// File: tb/triple_dac_if_test.sv
`timescale 1ns/1ps
module triple_dac_if_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
  logic [7:0] code_a, code_b, code_c;
  logic [1:0] state_a, state_b, state_c;
  logic lout;

  int errors = 0;
  int checks = 0;
  logic [7:0] m_code [3];
  logic [2:0] m_sd;
  logic       m_lo;
  bit done = 1'b0;

  always #2 clk = ~clk;

  triple_dac_if uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
    .code_a(code_a), .code_b(code_b), .code_c(code_c),
    .state_a(state_a), .state_b(state_b), .state_c(state_c), .lout(lout)
  );

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " code_a"}, code_a, m_code[0]);
    chk({tag, " code_b"}, code_b, m_code[1]);
    chk({tag, " code_c"}, code_c, m_sd[2] ? 0 : m_code[2]);
    chk({tag, " state_a"}, state_a, m_sd[0] ? 1 : 0);
    chk({tag, " state_b"}, state_b, m_sd[1] ? 1 : 0);
    chk({tag, " state_c"}, state_c, m_sd[2] ? 2 : 0);
    chk({tag, " lout"}, lout, m_lo);
  endtask

  task automatic shift_bits(input logic [15:0] w, input int nbits, input bit pause);
    cs_n = 1'b0;
    waitc(4);
    for (int i = 0; i < nbits; i++) begin
      sdin = (i < 16) ? w[15-i] : 1'b0;
      sclk = 1'b0; waitc(4);
      sclk = 1'b1; waitc(4);
      if (pause && i == 7) begin
        sclk = 1'b0; waitc(20);
      end
    end
    sclk = 1'b0;
    waitc(4);
  endtask

  task automatic release_cs();
    cs_n = 1'b1;
    waitc(12);
  endtask

  task automatic apply(input logic [15:0] w);
    for (int c = 0; c < 3; c++) if (w[8+c]) m_code[c] = w[7:0];
    m_sd = w[13:11];
    m_lo = w[14];
  endtask

  initial begin
    m_code[0] = 8'hFF; m_code[1] = 8'hFF; m_code[2] = 8'h00;
    m_sd = 3'b000; m_lo = 1'b0;
    waitc(5);
    chk_all("R1 in reset");
    rst = 1'b0;
    waitc(3);
    chk_all("R1 after reset");

    // R2: every load mask, distinct data
    for (int m = 0; m < 8; m++) begin
      logic [15:0] w;
      w = {5'b00000, 3'(m), 8'(8'h5A ^ (m * 37))};
      shift_bits(w, 16, 1'b0); release_cs();
      apply(w);
      chk_all($sformatf("R2 mask %0d", m));
    end

    // R5/R7: every shutdown mask, lout toggling
    for (int s = 0; s < 8; s++) begin
      logic [15:0] w;
      w = {1'b0, 1'(s[0] ^ 1), 3'(s), 3'b000, 8'h00};
      shift_bits(w, 16, 1'b0); release_cs();
      apply(w);
      chk_all($sformatf("R5 R7 shdn %0d", s));
    end

    // R6: leave shutdown, codes come back
    begin
      logic [15:0] w;
      w = {1'b0, 1'b1, 3'b111, 3'b000, 8'h00};
      shift_bits(w, 16, 1'b0); release_cs(); apply(w);
      w = {1'b0, 1'b0, 3'b000, 3'b000, 8'h00};
      shift_bits(w, 16, 1'b0); release_cs(); apply(w);
      chk_all("R6 restore");
    end

    // R3: split transfer
    begin
      logic [15:0] w;
      w = 16'h0797;
      shift_bits(w, 16, 1'b1); release_cs(); apply(w);
      chk_all("R3 split");
    end

    // R4: wrong lengths discarded
    shift_bits(16'h4F3C, 8, 1'b0);  release_cs(); chk_all("R4 8 bits");
    shift_bits(16'h4F3C, 15, 1'b0); release_cs(); chk_all("R4 15 bits");
    shift_bits(16'h4F3C, 17, 1'b0); release_cs(); chk_all("R4 17 bits");

    // R10: full word, select still low
    shift_bits(16'h4F3C, 16, 1'b0);
    waitc(12);
    chk_all("R10 before release");
    release_cs(); apply(16'h4F3C);
    chk_all("R10 after release");

    // R8: stray serial clocks while deselected
    sdin = 1'b1;
    for (int k = 0; k < 20; k++) begin
      sclk = 1'b1; waitc(4); sclk = 1'b0; waitc(4);
    end
    chk_all("R8 stray clocks");
    shift_bits(16'h0112, 16, 1'b0); release_cs(); apply(16'h0112);
    chk_all("R8 next word");

    // R9: bit 15 ignored
    shift_bits(16'h87C3, 16, 1'b0); release_cs(); apply(16'h07C3);
    chk_all("R9 top bit");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule